// File: doc/BRIEF.md
# Asynchronous External Bus Read Controller

This block runs read cycles on an asynchronous external memory bus whose timing is set by configuration inputs. A requester hands it an address and a zone number. The controller then drives three bus pins:

- one chip-select strobe per zone,
- a read strobe,
- a direction line.

It also drives a 20-bit address bus and two write-enable pins, and it captures a 16-bit or 32-bit data word from the bus. Each access runs through three phases: lead, active and trail. All three are counted in cycles of the timing clock (`clk`).

The bus clock either equals the timing clock or runs at half its rate. Output `bus_clk_hi` shows the bus-clock level for the current timing cycle. An access may only begin on a bus-clock rising edge. When a request arrives one cycle too early for that edge, the controller inserts one quiet alignment cycle first. Between accesses the address bus keeps the last address, with bit 0 forced high. In 16-bit mode the upper write-enable pin carries address bit 0 instead. An optional ready input can stretch the active phase.

The state machine has five states: IDLE, ALIGN, LEAD, ACTIVE and TRAIL. Its transitions are:

- **accept-aligned** (IDLE→LEAD): a request arrives and the next cycle is bus-clock high.
- **accept-misaligned** (IDLE→ALIGN): a request arrives and the next cycle is bus-clock low.
- **align-done** (ALIGN→LEAD).
- **lead-done** (LEAD→ACTIVE).
- **sample** (ACTIVE→TRAIL, or ACTIVE→IDLE when trail is 0): the active count has run out and ready permits.
- **stretch** (ACTIVE→ACTIVE): the count has run out, ready is in use and ready is low.
- **trail-done** (TRAIL→IDLE).

Top module: `xbus_rd_ctrl`

## Requirements
- R1: With `cfg_half_rate`=1, `bus_clk_hi` inverts on every timing cycle (it is 0 in the first cycle after reset release). With `cfg_half_rate`=0, it is constantly 1.
- R2: The first LEAD cycle always has `bus_clk_hi`=1. A request accepted while `bus_clk_hi`=1 in half-rate mode gets exactly one alignment cycle; every other request gets none. During the alignment cycle all `cs_n`, `rd_n`, `we0_n` and `we1_a0` are 1.
- R3: While no chip select is active, `bus_addr` equals the last access address with bit 0 forced to 1, and it does not change. During an access, `bus_addr` equals the requested address.
- R4: A lead count of 0 is treated as 1. Chip select is low for lead + (active+1) + trail cycles. `rd_n` goes low after exactly `lead` cycles of chip select and stays low for active+1 cycles. The trail lasts `cfg_trail` cycles after `rd_n` rises.
- R5: With `cfg_use_rdy`=1, `bus_rdy` is sampled at the end of each cycle from the (active+1)-th read cycle onward. While it is sampled low, `rd_n` stays low one more cycle at a time.
- R6: With `cfg_use_rdy`=0, `bus_rdy` has no effect on the read length.
- R7: `rd_data` takes `bus_din` as driven in the last `rd_n`-low cycle. `done` pulses for exactly one cycle, in the cycle right after that one. In 16-bit mode (`cfg_wide`=0) the upper 16 bits of `rd_data` are zero.
- R8: `rnw` and `we0_n` are always 1. `we1_a0` is 1 in 32-bit mode and equals `bus_addr[0]` in 16-bit mode.
- R9: `req_ready` is 1 only in IDLE. `busy` is 1 from the cycle after acceptance until the last trail cycle, and is 0 otherwise. A request raised while not ready is ignored.
- R10: Only `cs_n[zone]` goes low, for zones 0 to 2. Zone 3 runs the access with every chip select left high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low reset |
| cfg_lead | input | 4 | Lead length in cycles (0 treated as 1) |
| cfg_active | input | 4 | Active length minus one |
| cfg_trail | input | 3 | Trail length in cycles |
| cfg_use_rdy | input | 1 | 1: the ready input can stretch the active phase |
| cfg_half_rate | input | 1 | 1: bus clock runs at half the timing clock |
| cfg_wide | input | 1 | 1: 32-bit data, 0: 16-bit data |
| req_valid | input | 1 | Read request |
| req_addr | input | 20 | Request address |
| req_zone | input | 2 | Zone number |
| req_ready | output | 1 | Controller idle; the request is taken on this edge |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Captured read word |
| bus_clk_hi | output | 1 | Bus-clock level in this timing cycle |
| cs_n | output | 3 | Per-zone chip selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| rnw | output | 1 | Direction, 1 = read |
| we0_n | output | 1 | Lower write enable, always inactive |
| we1_a0 | output | 1 | Upper write enable, or address bit 0 in 16-bit mode |
| bus_addr | output | 20 | External address bus |
| bus_din | input | 32 | External read data |
| bus_rdy | input | 1 | External ready |

## Verification
The hardest condition to reach is the alignment cycle. It appears only when half-rate mode is set and the request lands in the one timing cycle where the divided clock is high. The bench reaches it by issuing back-to-back requests whose random phase lengths shift the acceptance cycle across both clock phases. For each access, the bench predicts whether alignment occurs from the `bus_clk_hi` value it sees in the acceptance cycle. A ready stall that starts exactly at the last counted active cycle is produced by driving ready from the bench's own count of read cycles.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ALIGN,
        S_LEAD,
        S_ACTIVE,
        S_TRAIL
    } xb_state_e;
endpackage

// File: rtl/xbus_clkgen.sv
module xbus_clkgen (
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate,
    output logic bus_clk_hi,
    output logic next_hi
);
    logic tgl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    always_comb begin
        bus_clk_hi = half_rate ? tgl_q  : 1'b1;
        next_hi    = half_rate ? ~tgl_q : 1'b1;
    end

    // R1: in half-rate mode the level alternates every cycle
    p_half_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (half_rate && $past(half_rate) && $past(rst_n)) |-> (bus_clk_hi != $past(bus_clk_hi)));
    // R1: full-rate level is always high
    p_full_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !half_rate |-> bus_clk_hi);
endmodule

// File: rtl/xbus_phase_cnt.sv
module xbus_phase_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int NZONE  = 3,
    parameter int ZSEL_W = 2
) (
    input  xb_state_e          state,
    input  logic [ZSEL_W-1:0]  zone,
    input  logic [ADDR_W-1:0]  addr_cur,
    input  logic [ADDR_W-1:0]  addr_last,
    input  logic               wide,
    output logic [NZONE-1:0]   cs_n,
    output logic               rd_n,
    output logic               rnw,
    output logic               we0_n,
    output logic               we1_a0,
    output logic [ADDR_W-1:0]  bus_addr
);
    logic in_acc;

    always_comb begin
        in_acc   = (state == S_LEAD) || (state == S_ACTIVE) || (state == S_TRAIL);
        bus_addr = in_acc ? addr_cur : {addr_last[ADDR_W-1:1], 1'b1};
        rd_n     = (state != S_ACTIVE);
        rnw      = 1'b1;
        we0_n    = 1'b1;
        we1_a0   = wide ? 1'b1 : bus_addr[0];
    end

    for (genvar g = 0; g < NZONE; g++) begin : g_cs
        assign cs_n[g] = !(in_acc && (zone == ZSEL_W'(g)));
    end
endmodule

// File: rtl/xbus_rd_ctrl.sv
module xbus_rd_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int NZONE  = 3,
    parameter int ZSEL_W = 2,
    parameter int LEAD_W = 4,
    parameter int ACT_W  = 4,
    parameter int TRL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEAD_W-1:0] cfg_lead,
    input  logic [ACT_W-1:0]  cfg_active,
    input  logic [TRL_W-1:0]  cfg_trail,
    input  logic              cfg_use_rdy,
    input  logic              cfg_half_rate,
    input  logic              cfg_wide,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ZSEL_W-1:0] req_zone,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_clk_hi,
    output logic [NZONE-1:0]  cs_n,
    output logic              rd_n,
    output logic              rnw,
    output logic              we0_n,
    output logic              we1_a0,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rdy
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MAX_LA = (LEAD_W > ACT_W) ? LEAD_W : ACT_W;
    localparam int CNT_W  = (MAX_LA > TRL_W) ? MAX_LA : TRL_W;

    xb_state_e          state_q, state_d;
    logic [LEAD_W-1:0]  lead_q;
    logic [ACT_W-1:0]   act_q;
    logic [TRL_W-1:0]   trl_q;
    logic               use_rdy_q, wide_q;
    logic [ADDR_W-1:0]  addr_q, last_q;
    logic [ZSEL_W-1:0]  zone_q;
    logic               next_hi, cnt_zero, cnt_load, capture, accept, in_acc;
    logic [CNT_W-1:0]   cnt_val;
    logic               done_q;
    logic [DATA_W-1:0]  rd_data_q;

    xbus_clkgen u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_rate (cfg_half_rate),
        .bus_clk_hi(bus_clk_hi),
        .next_hi   (next_hi)
    );

    xbus_phase_cnt #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .zero    (cnt_zero)
    );

    xbus_pinmux #(.ADDR_W(ADDR_W), .NZONE(NZONE), .ZSEL_W(ZSEL_W)) u_pins (
        .state    (state_q),
        .zone     (zone_q),
        .addr_cur (addr_q),
        .addr_last(last_q),
        .wide     (wide_q),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .rnw      (rnw),
        .we0_n    (we0_n),
        .we1_a0   (we1_a0),
        .bus_addr (bus_addr)
    );

    // lead length minus one, with a zero count treated as one
    function automatic logic [CNT_W-1:0] lead_m1(input logic [LEAD_W-1:0] v);
        return (v == '0) ? '0 : CNT_W'(v - 1'b1);
    endfunction

    // next-state and counter-load logic
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        capture  = 1'b0;
        accept   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (next_hi) begin
                        state_d  = S_LEAD;
                        cnt_load = 1'b1;
                        cnt_val  = lead_m1(cfg_lead);
                    end else begin
                        state_d  = S_ALIGN;
                    end
                end
            end
            S_ALIGN: begin
                state_d  = S_LEAD;
                cnt_load = 1'b1;
                cnt_val  = lead_m1(lead_q);
            end
            S_LEAD: begin
                if (cnt_zero) begin
                    state_d  = S_ACTIVE;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(act_q);
                end
            end
            S_ACTIVE: begin
                if (cnt_zero && (!use_rdy_q || bus_rdy)) begin
                    capture = 1'b1;
                    if (trl_q != '0) begin
                        state_d  = S_TRAIL;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(trl_q - 1'b1);
                    end else begin
                        state_d  = S_IDLE;
                    end
                end
            end
            S_TRAIL: begin
                if (cnt_zero) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request, configuration and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_q    <= '0;
            act_q     <= '0;
            trl_q     <= '0;
            use_rdy_q <= 1'b0;
            wide_q    <= 1'b1;
            addr_q    <= '0;
            zone_q    <= '0;
            last_q    <= '0;
            done_q    <= 1'b0;
            rd_data_q <= '0;
        end else begin
            if (accept) begin
                lead_q    <= cfg_lead;
                act_q     <= cfg_active;
                trl_q     <= cfg_trail;
                use_rdy_q <= cfg_use_rdy;
                wide_q    <= cfg_wide;
                addr_q    <= req_addr;
                zone_q    <= req_zone;
            end
            if (in_acc) last_q <= addr_q;
            done_q <= capture;
            if (capture)
                rd_data_q <= wide_q ? bus_din
                                    : {{(DATA_W-HALF_W){1'b0}}, bus_din[HALF_W-1:0]};
        end
    end

    // outputs
    always_comb begin
        in_acc    = (state_q == S_LEAD) || (state_q == S_ACTIVE) || (state_q == S_TRAIL);
        req_ready = (state_q == S_IDLE);
        busy      = (state_q != S_IDLE);
        done      = done_q;
        rd_data   = rd_data_q;
    end

    // R2: lead begins on a bus-clock high cycle
    p_lead_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LEAD && $past(state_q) != S_LEAD && $past(rst_n)) |-> bus_clk_hi);
    // R2: alignment cycle keeps every strobe inactive
    p_align_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ALIGN) |-> (&cs_n && rd_n && we0_n && we1_a0));
    // R3: bit 0 held high between accesses
    p_idle_a0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_acc |-> bus_addr[0]);
    // R3: idle address holds steady
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_acc && $past(!in_acc) && $past(rst_n)) |-> $stable(bus_addr));
    // R5: low ready at the end of active stretches it
    p_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACTIVE && cnt_zero && use_rdy_q && !bus_rdy) |=> (state_q == S_ACTIVE));
    // R6: ready ignored when not in use
    p_no_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACTIVE && cnt_zero && !use_rdy_q) |=> (state_q != S_ACTIVE));
    // R7: done lasts exactly one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: upper write enable stays inactive in 32-bit mode
    p_we1_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wide_q |-> we1_a0);
    // R9: an accepted request makes the block busy next cycle
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);
    // R10: at most one chip select active
    p_one_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
endmodule

// File: tb/sim_xbus_rd_ctrl.sv
module sim_xbus_rd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_lead = 4'd1;
    logic [3:0]  cfg_active = 4'd0;
    logic [2:0]  cfg_trail = 3'd0;
    logic        cfg_use_rdy = 1'b0, cfg_half_rate = 1'b0, cfg_wide = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_zone = '0;
    logic        req_ready, busy, done, bus_clk_hi, rd_n, rnw, we0_n, we1_a0;
    logic [31:0] rd_data;
    logic [2:0]  cs_n;
    logic [19:0] bus_addr;
    logic [31:0] bus_din = '0;
    logic        bus_rdy = 1'b0;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    xbus_rd_ctrl u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic int lead_eff(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    function automatic int rd_len_exp(input int a, input bit use_r, input int stall);
        return a + 1 + (use_r ? stall : 0);
    endfunction

    task automatic run_read(input logic [19:0] addr, input logic [1:0] zone, input int lead,
                            input int act, input int trl, input bit use_r, input bit half,
                            input bit wide, input int stall, input bit poke);
        bit h, exp_align, valid, bad_busy, bad_addr, bad_pins, bad_zone;
        int c, cs_len, rd_len, first_c, align_cnt, lead_seen, trl_seen, done_cnt, done_c, last_rd_c;
        logic [31:0] last_din, got, expd;
        c = 0; cs_len = 0; rd_len = 0; first_c = 0; align_cnt = 0; lead_seen = 0;
        trl_seen = 0; done_cnt = 0; done_c = 0; last_rd_c = 0; last_din = '0; got = '0;
        bad_busy = 0; bad_addr = 0; bad_pins = 0; bad_zone = 0;
        valid = (zone < 2'd3);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_lead = 4'(lead); cfg_active = 4'(act); cfg_trail = 3'(trl);
        cfg_use_rdy = use_r; cfg_half_rate = half; cfg_wide = wide;
        req_valid = 1'b1; req_addr = addr; req_zone = zone;
        #1;
        h = bus_clk_hi;
        exp_align = half && h;
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            c++;
            if (done) begin done_cnt++; done_c = c; got = rd_data; end
            if (req_ready) break;
            if (!busy) bad_busy = 1;
            if (!rnw || !we0_n || (we1_a0 != (wide ? 1'b1 : bus_addr[0]))) bad_pins = 1;
            if (valid) begin
                if (~&cs_n) begin
                    if (cs_n[zone] || $countones(~cs_n) != 1) bad_zone = 1;
                    cs_len++;
                    if (first_c == 0) begin
                        first_c = c;
                        if (!bus_clk_hi) bad_pins = 1;
                    end
                    if (bus_addr != addr) bad_addr = 1;
                end else begin
                    if (first_c == 0) begin
                        align_cnt++;
                        if (!rd_n || !we1_a0) bad_pins = 1;
                    end
                    if (!rd_n) bad_zone = 1;
                end
            end else if (~&cs_n) bad_zone = 1;
            if (!rd_n) begin
                rd_len++;
                last_rd_c = c;
                if (rd_len == 1) lead_seen = cs_len - 1;
            end else if (rd_len > 0 && ~&cs_n) trl_seen++;
            bus_din = $urandom;
            if (!rd_n) last_din = bus_din;
            bus_rdy = use_r ? (!rd_n && rd_len >= act + 1 + stall) : 1'b0;
            if (poke && c == 1) begin req_valid = 1'b1; req_addr = ~addr; end
            if (poke && c == 2) req_valid = 1'b0;
            if (c > 400) break;
            @(negedge clk);
        end
        bus_rdy = 1'b0;
        chk(rd_len == rd_len_exp(act, use_r, stall), use_r ? "R5 read strobe length" : "R6 read strobe length",
            32'(rd_len), 32'(rd_len_exp(act, use_r, stall)));
        expd = wide ? last_din : {16'h0, last_din[15:0]};
        chk(done_cnt == 1 && done_c == last_rd_c + 1, "R7 done timing", 32'(done_c), 32'(last_rd_c + 1));
        chk(got == expd, "R7 captured word", got, expd);
        chk(!bad_pins, "R8 rnw/we0_n/we1_a0 pins", 32'(bad_pins), 32'd0);
        chk(!bad_busy && !busy, "R9 busy window", 32'(bad_busy), 32'd0);
        chk(!bad_zone, "R10 zone select", 32'(bad_zone), 32'd0);
        chk(bus_addr == {addr[19:1], 1'b1} && &cs_n, "R3 idle address", 32'(bus_addr), 32'({addr[19:1], 1'b1}));
        if (valid) begin
            chk(align_cnt == 32'(exp_align), "R2 alignment cycles", 32'(align_cnt), 32'(exp_align));
            chk(cs_len == lead_eff(lead) + rd_len_exp(act, use_r, stall) + trl, "R4 chip-select length",
                32'(cs_len), 32'(lead_eff(lead) + rd_len_exp(act, use_r, stall) + trl));
            chk(lead_seen == lead_eff(lead) && trl_seen == trl, "R4 lead/trail split",
                32'(lead_seen * 16 + trl_seen), 32'(lead_eff(lead) * 16 + trl));
            chk(!bad_addr, "R3 access address", 32'(bad_addr), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        bit prev, ok;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready && !busy && !done && &cs_n && rd_n && bus_addr == 20'h00001,
            "R9 reset state", 32'(bus_addr), 32'h1);
        rst_n = 1'b1;
        // R1: bus clock level in both modes
        cfg_half_rate = 1'b1;
        @(negedge clk); prev = bus_clk_hi; ok = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (bus_clk_hi == prev) ok = 0;
            prev = bus_clk_hi;
        end
        chk(ok, "R1 half-rate toggle", 32'(ok), 32'd1);
        cfg_half_rate = 1'b0; ok = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!bus_clk_hi) ok = 0;
        end
        chk(ok, "R1 full-rate level", 32'(ok), 32'd1);
        // directed corner cases
        run_read(20'h12345, 2'd0, 1, 0, 0, 0, 0, 1, 0, 0);   // shortest access
        run_read(20'hABCDE, 2'd1, 0, 2, 1, 0, 1, 0, 0, 0);   // lead 0, 16-bit
        run_read(20'h0F0F0, 2'd2, 3, 1, 2, 1, 1, 1, 3, 0);   // R5 stall
        run_read(20'h55554, 2'd0, 2, 1, 0, 0, 0, 1, 3, 0);   // R6 ready ignored
        run_read(20'h33333, 2'd3, 2, 1, 1, 0, 0, 1, 0, 0);   // R10 invalid zone
        run_read(20'h7A7A6, 2'd1, 4, 3, 3, 0, 1, 0, 0, 1);   // R9 request while busy
        // constrained random, back to back
        for (int k = 0; k < 80; k++) begin
            run_read(20'($urandom), 2'($urandom % 3), int'($urandom % 6), int'($urandom % 4),
                     int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2),
                     bit'($urandom % 2), int'($urandom % 4), 1'b0);
        end
        summary();
    end
endmodule